// File: doc/BRIEF.md
# Root Port Memory Window Decoder

This block sits on the request path of a PCI Express root port and decides whether a memory request address belongs to the port. It holds two address windows. One is a plain, non-prefetchable window that covers only the space below 4 GB. The other is a prefetchable window whose base and limit can be extended with upper bits, so it can sit above 4 GB.

Both windows use 1 MB granularity. A programmed base covers address bits 31:20, and its low twenty bits are taken as zero. A programmed limit covers the same bits, and its low twenty bits are taken as all ones. Configuration software loads the windows and a command enable bit through a simple register-write port.

Each valid request produces, one cycle later, a valid strobe together with a hit flag for each window and a combined route flag. The prefetchable hit is reported separately, so that downstream logic can give that range its own caching attribute.

Top module: `memwin_decoder`

## Requirements
- R1: After reset, rsp_valid, hit_np, hit_pf and route_port are 0. Every window resets empty (base field all ones, limit field zero, upper base 4'hF, upper limit 4'h0) and the enable bit resets to 0. A request made after reset without any programming therefore never hits.
- R2: The plain window hits when addr[35:32] is zero and {base,20'h00000} <= addr[31:0] <= {limit,20'hFFFFF}. Both bounds are inclusive.
- R3: The prefetchable window hits when {ubase,base,20'h00000} <= addr <= {ulimit,limit,20'hFFFFF}, compared over the full 36 bits. Both bounds are inclusive.
- R4: A window whose full limit is below its full base is empty and never reports a hit.
- R5: While the enable bit (bit 0 of the command register) is 0, neither hit_np nor hit_pf is ever 1.
- R6: rsp_valid is 1 exactly in the cycle after a cycle with req_valid=1. All hit outputs are 0 whenever rsp_valid is 0.
- R7: route_port equals hit_np OR hit_pf.
- R8: A write takes effect at the clock edge where wr_en=1 and wr_sel picks the register. The selects are: 0 = command (wr_data[0] is the enable); 1 = plain base; 2 = plain limit; 3 = prefetchable base; 4 = prefetchable limit (for selects 1 to 4, wr_data[15:4] holds address bits 31:20); 5 = prefetchable upper base; 6 = prefetchable upper limit (for selects 5 and 6, wr_data[3:0] holds address bits 35:32). A write with select 7 changes nothing.
- R9: When a request and a write fall in the same cycle, the request is decoded with the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 36 | Request address |
| rsp_valid | output | 1 | Decode result valid, one cycle after request |
| hit_np | output | 1 | Plain window hit |
| hit_pf | output | 1 | Prefetchable window hit |
| route_port | output | 1 | Request is claimed by the port |

## Verification
Two functions can fall in the same cycle: a configuration write, and the decode of a request that the write would affect. The bench issues a request in the same cycle as a write that opens a window around the request address, and also in the same cycle as a write that clears the enable bit. It expects the result computed from the register state before the write, and then repeats the same request alone to confirm that the new value has taken effect.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    localparam int ADDR_W  = 36;
    localparam int GRAN_W  = 20;
    localparam int LOW_W   = 32;
    localparam int MB_W    = LOW_W - GRAN_W;
    localparam int UP_W    = ADDR_W - LOW_W;
    localparam int DATA_W  = 16;
    localparam int SEL_W   = 3;
    localparam int NWIN    = 2;
    localparam int WIN_NP  = 0;
    localparam int WIN_PF  = 1;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMD     = 3'd0,
        SEL_NP_BASE = 3'd1,
        SEL_NP_LIM  = 3'd2,
        SEL_PF_BASE = 3'd3,
        SEL_PF_LIM  = 3'd4,
        SEL_PF_UBAS = 3'd5,
        SEL_PF_ULIM = 3'd6,
        SEL_NONE    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [UP_W-1:0] base_hi;
        logic [MB_W-1:0] base_mb;
        logic [UP_W-1:0] lim_hi;
        logic [MB_W-1:0] lim_mb;
    } win_cfg_t;

    localparam win_cfg_t WIN_EMPTY = '{base_hi: '1, base_mb: '1, lim_hi: '0, lim_mb: '0};

    function automatic logic [ADDR_W-1:0] win_low(input win_cfg_t c);
        return {c.base_hi, c.base_mb, {GRAN_W{1'b0}}};
    endfunction

    function automatic logic [ADDR_W-1:0] win_high(input win_cfg_t c);
        return {c.lim_hi, c.lim_mb, {GRAN_W{1'b1}}};
    endfunction
endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
    import memwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output win_cfg_t          np_cfg,
    output win_cfg_t          pf_cfg,
    output logic              mem_en
);
    localparam int FLD_LSB = DATA_W - MB_W;

    win_cfg_t np_q, pf_q;
    logic     en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            np_q <= WIN_EMPTY;
            pf_q <= WIN_EMPTY;
            en_q <= 1'b0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_CMD:     en_q         <= wr_data[0];
                SEL_NP_BASE: np_q.base_mb <= wr_data[DATA_W-1:FLD_LSB];
                SEL_NP_LIM:  np_q.lim_mb  <= wr_data[DATA_W-1:FLD_LSB];
                SEL_PF_BASE: pf_q.base_mb <= wr_data[DATA_W-1:FLD_LSB];
                SEL_PF_LIM:  pf_q.lim_mb  <= wr_data[DATA_W-1:FLD_LSB];
                SEL_PF_UBAS: pf_q.base_hi <= wr_data[UP_W-1:0];
                SEL_PF_ULIM: pf_q.lim_hi  <= wr_data[UP_W-1:0];
                default: ;
            endcase
        end
    end

    assign np_cfg = np_q;
    assign pf_cfg = pf_q;
    assign mem_en = en_q;

    p_sel7_keeps_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_NONE) |=> ($stable(np_q) && $stable(pf_q) && $stable(en_q)));
endmodule

// File: rtl/memwin_match.sv
module memwin_match
    import memwin_pkg::*;
#(
    parameter bit HAS_HI = 1'b1
) (
    input  win_cfg_t          cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    win_cfg_t eff;

    generate
        if (HAS_HI) begin : g_ext
            assign eff = cfg;
        end else begin : g_low
            always_comb begin
                eff         = cfg;
                eff.base_hi = '0;
                eff.lim_hi  = '0;
            end
        end
    endgenerate

    logic [ADDR_W-1:0] lo, hi;
    assign lo  = win_low(eff);
    assign hi  = win_high(eff);
    assign hit = (addr >= lo) && (addr <= hi);

    always_comb begin
        p_empty_nohit_r4: assert (!(hit && (hi < lo)));
    end
endmodule

// File: rtl/memwin_decoder.sv
module memwin_decoder
    import memwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              hit_np,
    output logic              hit_pf,
    output logic              route_port
);
    win_cfg_t cfg [NWIN];
    logic     mem_en;
    logic [NWIN-1:0] raw_hit;

    memwin_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .np_cfg (cfg[WIN_NP]),
        .pf_cfg (cfg[WIN_PF]),
        .mem_en (mem_en)
    );

    generate
        for (genvar w = 0; w < NWIN; w++) begin : g_win
            memwin_match #(.HAS_HI(w == WIN_PF)) u_match (
                .cfg (cfg[w]),
                .addr(req_addr),
                .hit (raw_hit[w])
            );
        end
    endgenerate

    logic [NWIN-1:0] gated;
    assign gated = (req_valid && mem_en) ? raw_hit : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            hit_np     <= 1'b0;
            hit_pf     <= 1'b0;
            route_port <= 1'b0;
        end else begin
            rsp_valid  <= req_valid;
            hit_np     <= gated[WIN_NP];
            hit_pf     <= gated[WIN_PF];
            route_port <= |gated;
        end
    end

    p_rsp_follows_req_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_no_hit_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !(hit_np || hit_pf || route_port));
    p_gate_en_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_en |=> !(hit_np || hit_pf));
    p_np_low4g_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[ADDR_W-1:LOW_W] != '0) |=> !hit_np);
    p_route_or_r7: assert property (@(posedge clk) disable iff (rst)
        route_port == (hit_np || hit_pf));
endmodule

// File: tb/memwin_decoder_tb.sv
module memwin_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic        req_valid;
    logic [35:0] req_addr;
    logic        rsp_valid, hit_np, hit_pf, route_port;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    memwin_decoder dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
        .hit_np(hit_np), .hit_pf(hit_pf), .route_port(route_port)
    );

    // bench model of the programmed state
    logic        m_en;
    logic [11:0] m_nb, m_nl, m_pb, m_pl;
    logic [3:0]  m_pbh, m_plh;

    function automatic bit exp_np(input logic [35:0] a);
        return m_en && a[35:32] == 4'h0 &&
               a[31:0] >= {m_nb, 20'h0} && a[31:0] <= {m_nl, 20'hFFFFF};
    endfunction

    function automatic bit exp_pf(input logic [35:0] a);
        return m_en && a >= {m_pbh, m_pb, 20'h0} && a <= {m_plh, m_pl, 20'hFFFFF};
    endfunction

    task automatic model_write(input logic [2:0] s, input logic [15:0] d);
        case (s)
            3'd0: m_en  = d[0];
            3'd1: m_nb  = d[15:4];
            3'd2: m_nl  = d[15:4];
            3'd3: m_pb  = d[15:4];
            3'd4: m_pl  = d[15:4];
            3'd5: m_pbh = d[3:0];
            3'd6: m_plh = d[3:0];
            default: ;
        endcase
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {valid,np,pf,route} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(s, d);
    endtask

    // request, optionally with a write in the same cycle
    task automatic req(input string tag, input logic [35:0] a,
                       input bit with_wr, input logic [2:0] s, input logic [15:0] d);
        bit en, pf;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        wr_en = with_wr; wr_sel = s; wr_data = d;
        en = exp_np(a); pf = exp_pf(a);
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        if (with_wr) model_write(s, d);
        check(tag, {rsp_valid, hit_np, hit_pf, route_port}, {1'b1, en, pf, en | pf});
    endtask

    task automatic rq(input string tag, input logic [35:0] a);
        req(tag, a, 1'b0, 3'd0, 16'h0);
    endtask

    initial begin
        #20000000;
        n_fail++; n_tests++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; wr_en = 0; wr_sel = 0; wr_data = 0; req_valid = 0; req_addr = 0;
        m_en = 0; m_nb = 12'hFFF; m_nl = 0; m_pb = 12'hFFF; m_pl = 0; m_pbh = 4'hF; m_plh = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 reset outputs", {rsp_valid, hit_np, hit_pf, route_port}, 4'b0000);
        wr(3'd0, 16'h0001);
        rq("R1 empty after reset", 36'h0_0000_0000);
        rq("R1 empty after reset hi", 36'hF_FFFF_FFFF);
        // R6 idle output
        @(negedge clk);
        check("R6 idle", {rsp_valid, hit_np, hit_pf, route_port}, 4'b0000);

        // R8 program plain 0x100..0x1FF MB, prefetchable 0x4_800..0x4_9FF
        wr(3'd1, {12'h100, 4'h0});
        wr(3'd2, {12'h1FF, 4'hA});
        wr(3'd3, {12'h800, 4'h0});
        wr(3'd4, {12'h9FF, 4'h0});
        wr(3'd5, 16'h0004);
        wr(3'd6, 16'h0004);
        // R2 inclusive edges
        rq("R2 np base", 36'h0_1000_0000);
        rq("R2 np below", 36'h0_0FFF_FFFF);
        rq("R2 np limit", 36'h0_1FFF_FFFF);
        rq("R2 np above", 36'h0_2000_0000);
        rq("R2 np upper bits", 36'h1_1000_0000);
        // R3 above 4 GB
        rq("R3 pf base", 36'h4_8000_0000);
        rq("R3 pf limit", 36'h4_9FFF_FFFF);
        rq("R3 pf below", 36'h4_7FFF_FFFF);
        rq("R3 pf alias low", 36'h0_8000_0000);
        rq("R3 pf above", 36'h4_A000_0000);
        // R8 select 7 ignored: try to move plain base; edge still hits
        wr(3'd7, 16'h0000);
        rq("R8 sel7 ignored", 36'h0_1000_0000);
        rq("R8 sel7 ignored below", 36'h0_0FFF_FFFF);
        // R4 inverted window
        wr(3'd2, {12'h0FF, 4'h0});
        rq("R4 inverted np", 36'h0_1000_0000);
        rq("R4 inverted np 2", 36'h0_0FF0_0000);
        // R9 write in same cycle opening window
        req("R9 same-cycle write old", 36'h0_1800_0000, 1'b1, 3'd2, {12'h1FF, 4'h0});
        rq("R9 after write new", 36'h0_1800_0000);
        // R9 disable in same cycle: old enable still applies
        req("R9 same-cycle disable", 36'h4_8000_0000, 1'b1, 3'd0, 16'h0000);
        // R5 disabled
        rq("R5 disabled np", 36'h0_1800_0000);
        rq("R5 disabled pf", 36'h4_8000_0000);
        wr(3'd0, 16'h0001);
        rq("R7 route re-enabled", 36'h4_8000_0000);

        // random phase: R2 R3 R4 R5 R7
        for (int i = 0; i < 400; i++) begin
            logic [35:0] a;
            int k;
            if (i % 40 == 0) begin
                wr(3'd1, 16'($urandom));
                wr(3'd2, 16'($urandom));
                wr(3'd3, 16'($urandom));
                wr(3'd4, 16'($urandom));
                wr(3'd5, 16'($urandom));
                wr(3'd6, 16'($urandom));
                wr(3'd0, 16'($urandom_range(0, 3) != 0));
            end
            k = $urandom_range(0, 5);
            case (k)
                0: a = {4'h0, m_nb, 20'h0};
                1: a = {4'h0, m_nl, 20'hFFFFF};
                2: a = {m_pbh, m_pb, 20'h0} - 36'd1;
                3: a = {m_plh, m_pl, 20'hFFFFF} + 36'd1;
                4: a = {m_pbh, m_pb, 20'h0};
                default: a = {4'($urandom), 32'($urandom)};
            endcase
            rq("R7 random", a);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule